// File: doc/BRIEF.md
# Alternating One-Place Buffer

This block passes words from a producer to a consumer through a single storage register. A free-running slot bit flips on every clock, and the producer and the consumer take turns by that bit: a write is accepted only in a write slot, and a read is served only in a read slot. A read and a write therefore never share a cycle, and every read lies strictly between two successive write slots. The slot bit alone settles which side is served. No full or empty tracking exists.

The producer watches `wr_slot` and raises `wr_valid` with `wr_data` in a write slot. The consumer raises `rd_req` and takes `rd_data` in a cycle where `rd_valid` is high. A read returns whatever the register last took in. A write offered in a read slot is discarded and raises `proto_err` in that same cycle. A synchronous reset puts the slot bit back to its start value and clears the register.

Top module: `alt_slot_buffer`

## Requirements
- R1: In the first cycle after reset is released, `wr_slot` is 0 (read slot). After that it inverts on every clock edge.
- R2: When `wr_valid` is high while `wr_slot` is 1, `wr_data` is stored at that clock edge.
- R3: When `wr_valid` is high while `wr_slot` is 0, the word is discarded and the stored word is left unchanged. `proto_err` is high in exactly that cycle.
- R4: `rd_valid` is high only in cycles where `rd_req` is high and `wr_slot` is 0. While `rd_valid` is high, `rd_data` equals the stored word.
- R5: `rd_req` raised in a write slot gets no read (`rd_valid` stays 0). A write offered in that same cycle is still stored.
- R6: The stored word is zero after reset, so a read before any write returns 0.
- R7: Without an accepted write, the stored word is held, and repeated reads return the same value.
- R8: With the default setting `ZERO_IDLE=1`, `rd_data` is 0 whenever `rd_valid` is low.
- R9: Accepted writes never happen in two consecutive cycles, and never in a cycle where `rd_valid` is high.
- R10: A synchronous reset asserted mid-stream returns `wr_slot` to 0 in the next cycle and clears the stored word to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Producer word |
| wr_slot | output | 1 | 1 in a write slot, 0 in a read slot |
| proto_err | output | 1 | Write offered in a read slot (discarded) |
| rd_req | input | 1 | Consumer asks for a word |
| rd_valid | output | 1 | Read served this cycle |
| rd_data | output | DATA_W | Stored word while rd_valid is high |

## Verification
Some properties are checked by assertions on every cycle:
- the slot bit inverts on each edge;
- an accepted write lands in the register;
- a discarded write leaves the register untouched;
- a served read presents the register contents;
- writes and reads never coincide.

Other behaviour only the bench scenarios can show:
- the start phase after reset;
- that the register is zero before the first write;
- that idle output is zero;
- that a mid-stream reset clears the stored word.

These are shown by driving sequences with known expected words at the ports.

// File: rtl/alt_slot_pkg.sv
package alt_slot_pkg;
   typedef enum logic {
      SLOT_READ  = 1'b0,
      SLOT_WRITE = 1'b1
   } slot_e;

   localparam logic PRE_SLOT_INIT = 1'b1;
endpackage

// File: rtl/alt_slot_phase.sv
module alt_slot_phase
   import alt_slot_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   output slot_e slot
);
   logic prev_q;

   assign slot = slot_e'(~prev_q);

   always_ff @(posedge clk) begin
      if (rst) prev_q <= PRE_SLOT_INIT;
      else     prev_q <= logic'(slot);
   end

   // R1: slot flips on every edge out of reset
   p_slot_toggle_r1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (slot != $past(slot)));
endmodule

// File: rtl/alt_slot_cell.sv
module alt_slot_cell #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/alt_slot_buffer.sv
module alt_slot_buffer
   import alt_slot_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_slot,
   output logic              proto_err,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("alt_slot_buffer: DATA_W must be at least 1");
      end
   endgenerate

   slot_e            slot;
   logic             wr_fire;
   logic [MSB:0]     cell_q;

   alt_slot_phase u_phase (
      .clk  (clk),
      .rst  (rst),
      .slot (slot)
   );

   assign wr_slot   = (slot == SLOT_WRITE);
   assign wr_fire   = wr_valid & wr_slot;
   assign proto_err = wr_valid & ~wr_slot;
   assign rd_valid  = rd_req & (slot == SLOT_READ);

   alt_slot_cell #(.DATA_W(DATA_W)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .load (wr_fire),
      .din  (wr_data),
      .dout (cell_q)
   );

   generate
      if (ZERO_IDLE) begin : g_mask_idle
         assign rd_data = rd_valid ? cell_q : '0;
      end else begin : g_show_cell
         assign rd_data = cell_q;
      end
   endgenerate

   // R2: accepted word lands in the cell
   p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_slot) |=> (cell_q == $past(wr_data)));

   // R3: discarded word leaves the cell untouched
   p_drop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_slot) |=> $stable(cell_q));

   // R4: served read presents the cell
   p_read_cell_r4: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> (rd_data == cell_q));

   // R9: accepted writes are never back to back
   p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
      wr_fire |=> !wr_fire);

   // R9: read and write never share a cycle
   p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (rst)
      !(wr_fire && rd_valid));
endmodule

// File: tb/alt_slot_buffer_tb.sv
module alt_slot_buffer_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_valid = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rd_req = 1'b0;
   logic         wr_slot, proto_err, rd_valid;
   logic [W-1:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   alt_slot_buffer #(.DATA_W(W), .ZERO_IDLE(1'b1)) u_dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_slot(wr_slot), .proto_err(proto_err), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // {wr_valid, wr_data, rd_req, exp_slot, exp_rd_valid, exp_rd_data, exp_err}
   localparam int NV = 13;
   localparam logic [20:0] VEC [NV] = '{
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},  // R6 R1 read before write
      {1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // R2 write
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b0},  // R4 read
      {1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},  // R5 read asked in write slot
      {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b1},  // R3 write in read slot
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0},  // R3 R7 drop had no effect
      {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0},  // R7 hold
      {1'b1, 8'h81, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R8 idle output zero
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h81, 1'b0}   // R9 alternation kept
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R10 reset slot", {7'd0, wr_slot}, 8'd0);
      check("R8 reset rd_valid", {7'd0, rd_valid}, 8'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst      = 1'b0;
         wr_valid = VEC[i][20];
         wr_data  = VEC[i][19:12];
         rd_req   = VEC[i][11];
         #2;
         check($sformatf("R1 slot v%0d", i), {7'd0, wr_slot}, {7'd0, VEC[i][10]});
         check($sformatf("R4 rd_valid v%0d", i), {7'd0, rd_valid}, {7'd0, VEC[i][9]});
         check($sformatf("R4 rd_data v%0d", i), rd_data, VEC[i][8:1]);
         check($sformatf("R3 proto_err v%0d", i), {7'd0, proto_err}, {7'd0, VEC[i][0]});
      end

      // R10: reset mid-stream after 0x81 was stored
      @(negedge clk);
      wr_valid = 1'b0;
      rd_req   = 1'b0;
      rst      = 1'b1;
      @(negedge clk);
      rst    = 1'b0;
      rd_req = 1'b1;
      #2;
      check("R10 slot after reset", {7'd0, wr_slot}, 8'd0);
      check("R10 cell cleared", rd_data, 8'h00);

      // R1: slot keeps alternating
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         #2;
         check("R1 toggle", {7'd0, wr_slot}, {7'd0, 1'(k % 2)});
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule